// File: doc/BRIEF.md
# Timer with Shared Watchdog Prescaler

This block is an 8-bit free-running timer. It shares a single 8-bit prescaler with an external watchdog counter, and software can move the prescaler between the two at any time. The timer counts one of two sources. The first is the internal instruction-cycle tick. The second is an external pin, with a programmable active edge. Pin edges are synchronized to the block clock before they are counted. Every counting event passes through a two-instruction-cycle pipeline before it reaches the timer register.

When the timer wraps from all ones to zero, it sets a sticky interrupt flag. The interrupt request is that flag gated by an enable bit. A small register port gives write and read access to the timer value, an option byte and an interrupt-control byte.

The oscillator behind the watchdog tick, the watchdog timeout counter and the chip interrupt controller all sit outside this block. The block receives the raw watchdog tick and returns either that tick or a divided version of it. When the sleep input is high, the timer does not count, so it can never raise a wake-up.

Top module: `tmr_wdt_prescaler`

## Requirements
- R1: After reset the option byte reads FFh, the timer reads 00h, the interrupt-control byte reads 00h and irq_o is low.
- R2: Register map by addr_i: 0 = timer, 1 = option, 2 = interrupt control, 3 reads 00h. Option byte fields: bits [2:0] tap select, bit 3 prescaler-to-watchdog, bit 4 falling-edge select, bit 5 external-source select, bits [7:6] spare storage. Interrupt-control fields: bit 0 overflow flag, bit 1 enable. Written values read back.
- R3: With external-source select at 0, the timer counts cycles in which cyc_tick_i is high and holds while it is low.
- R4: With external-source select at 1, the timer counts rising edges of ext_clk_i when falling-edge select is 0 and falling edges when it is 1. Edges of the other polarity and cyc_tick_i have no effect.
- R5: With prescaler-to-watchdog at 0, the timer advances once every 2^(tap+1) source events (1:2 up to 1:256).
- R6: With prescaler-to-watchdog at 1, wdt_tick_o pulses once every 2^tap wdt_tick_i pulses and the timer counts every source event. With it at 0, wdt_tick_o equals wdt_tick_i.
- R7: A timer write loads wdata_i. A timer or option write clears the prescaler and the pending-event pipeline. A source event raises the timer in the third cycle after it occurs, so the written value holds for two instruction cycles.
- R8: The overflow flag sets on the wrap from FFh to 00h. It stays set until software writes bit 0 to 0. When an overflow and a write occur in the same cycle, the set wins.
- R9: irq_o is high exactly when the flag and the enable bit are both set.
- R10: While sleep_i is high the timer does not count and pending events are dropped. The watchdog path keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_tick_i | input | 1 | Instruction-cycle tick enable |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| sleep_i | input | 1 | Sleep state, stops the timer |
| wdt_tick_i | input | 1 | Raw watchdog oscillator tick |
| wdt_tick_o | output | 1 | Tick to the watchdog counter, divided or not |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The internal source is driven in three ways: a tick held high, a tick held low, and a tick restored after a gap. Together these show that only ticked cycles count. The external pin is pulsed with both edge settings, and the timer is sampled between the rising and falling halves of each pulse, which shows which edge counts. The prescaler is run at taps 0, 2 and 7 in the timer path, and at tap 2 in the watchdog path. This separates the 2^(tap+1) timer division from the 2^tap watchdog division and from pass-through. Writes of FEh and FFh place the wrap at a known cycle, so the check can tell the flag set, its sticky hold, the write clear and enable gating apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_TMR = 2'd0,
    SEL_OPT = 2'd1,
    SEL_INT = 2'd2,
    SEL_RSV = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] spare;
    logic       src_ext;
    logic       edge_fall;
    logic       pre_to_wdt;
    logic [2:0] tap;
  } opt_t;

  localparam logic [DATA_W-1:0] OPT_RST = 8'hFF;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_tick_i,
  input  logic ext_clk_i,
  input  logic edge_fall_i,
  input  logic src_ext_i,
  input  logic sleep_i,
  output logic src_pulse_o
);
  logic [SYNC_N-1:0] pin_sync_q;
  logic lvl, lvl_q, ext_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_sync_q <= '0;
    else         pin_sync_q <= {pin_sync_q[SYNC_N-2:0], ext_clk_i};
  end

  assign lvl = pin_sync_q[SYNC_N-1] ^ edge_fall_i;

  // reset level matches pin low with falling select, so no edge at start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl;
  end

  assign ext_edge    = lvl & ~lvl_q;
  assign src_pulse_o = ~sleep_i & (src_ext_i ? ext_edge : cyc_tick_i);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned TAP_W = $clog2(CNT_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             tap_pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // hit[k]: the next input event completes a 2^k division
  assign hit[0] = 1'b1;
  for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
    assign hit[k] = &cnt_q[k-1:0];
  end

  assign tap_pulse_o = inc_i & (tap_i <= TAP_W'(CNT_W)) & hit[tap_i];
endmodule

// File: rtl/tmr_sync_count.sv
module tmr_sync_count #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cyc_tick_i,
  input  logic         pulse_i,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [STAGES-1:0] stg_q;
  logic [W-1:0]      cnt_q;
  logic              inc;

  // event pipeline advances one stage per instruction cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else if (clr_i) stg_q <= '0;
    else begin
      if (cyc_tick_i) stg_q[0] <= pulse_i;
      else            stg_q[0] <= stg_q[0] | pulse_i;
      for (int i = 1; i < int'(STAGES); i++) begin
        if (cyc_tick_i) stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign inc = cyc_tick_i & stg_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = inc & (&cnt_q) & ~ld_i;
endmodule

// File: rtl/tmr_wdt_prescaler.sv
module tmr_wdt_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned SYNC_N  = 2,
  parameter int unsigned CYC_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_tick_i,
  input  logic              ext_clk_i,
  input  logic              sleep_i,
  input  logic              wdt_tick_i,
  output logic              wdt_tick_o,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned TAP_W = $clog2(PRE_W + 1);

  opt_t              opt_q;
  logic              flag_q, en_q;
  logic              wr_tmr, wr_opt, wr_int, pipe_clr;
  logic              src_pulse, pre_in, pre_pulse, tmr_pulse, ovf;
  logic [TAP_W-1:0]  tap_sel;
  logic [DATA_W-1:0] tmr_val;

  assign wr_tmr   = wr_en_i && (reg_sel_e'(addr_i) == SEL_TMR);
  assign wr_opt   = wr_en_i && (reg_sel_e'(addr_i) == SEL_OPT);
  assign wr_int   = wr_en_i && (reg_sel_e'(addr_i) == SEL_INT);
  assign pipe_clr = wr_tmr | wr_opt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     opt_q <= opt_t'(OPT_RST);
    else if (wr_opt) opt_q <= opt_t'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (ovf)         flag_q <= 1'b1;
      else if (wr_int) flag_q <= wdata_i[0];
      if (wr_int)      en_q   <= wdata_i[1];
    end
  end

  tmr_src_sel #(.SYNC_N(SYNC_N)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_tick_i  (cyc_tick_i),
    .ext_clk_i   (ext_clk_i),
    .edge_fall_i (opt_q.edge_fall),
    .src_ext_i   (opt_q.src_ext),
    .sleep_i     (sleep_i),
    .src_pulse_o (src_pulse)
  );

  // timer path taps one stage deeper than the watchdog path
  assign tap_sel = TAP_W'(opt_q.tap) + TAP_W'(!opt_q.pre_to_wdt);
  assign pre_in  = opt_q.pre_to_wdt ? wdt_tick_i : src_pulse;

  tmr_prescaler #(.CNT_W(PRE_W)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (pipe_clr),
    .inc_i       (pre_in),
    .tap_i       (tap_sel),
    .tap_pulse_o (pre_pulse)
  );

  assign tmr_pulse  = opt_q.pre_to_wdt ? src_pulse : pre_pulse;
  assign wdt_tick_o = opt_q.pre_to_wdt ? pre_pulse : wdt_tick_i;

  tmr_sync_count #(.W(DATA_W), .STAGES(CYC_DLY)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_tick_i (cyc_tick_i),
    .pulse_i    (tmr_pulse),
    .clr_i      (pipe_clr | sleep_i),
    .ld_i       (wr_tmr),
    .ld_val_i   (wdata_i),
    .cnt_o      (tmr_val),
    .ovf_o      (ovf)
  );

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_TMR: rdata_o = tmr_val;
      SEL_OPT: rdata_o = opt_q;
      SEL_INT: rdata_o = {{(DATA_W-2){1'b0}}, en_q, flag_q};
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q & en_q;
endmodule

// File: rtl/tmr_wdt_chk.sv
module tmr_wdt_chk
  import tmr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              sleep_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] tmr_q,
  input logic              flag_q
);
  logic wr_t, wr_i;
  assign wr_t = wr_en_i && (addr_i == 2'd0);
  assign wr_i = wr_en_i && (addr_i == 2'd2);

  // R8
  wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q == '0 && $past(tmr_q) == '1 && !$past(wr_t)) |-> flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_q) && !$past(wr_i)) |-> flag_q);

  // R7
  write_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_t, 2) && !$past(wr_en_i)) |-> tmr_q == $past(wdata_i, 2));

  // R9
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && !wdata_i[1]) |-> !irq_o);

  // R10
  sleep_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sleep_i, 3) && !$past(wr_en_i)) |-> $stable(tmr_q));
endmodule

bind tmr_wdt_prescaler tmr_wdt_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .sleep_i (sleep_i),
  .irq_o   (irq_o),
  .tmr_q   (tmr_val),
  .flag_q  (flag_q)
);

// File: tb/tmr_wdt_prescaler_tb.sv
`timescale 1ns/1ps
module tmr_wdt_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc = 1'b1, pin = 1'b0, sleep = 1'b0, wdt_in = 1'b0;
  logic       wdt_out, irq;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tmr_wdt_prescaler u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_tick_i(cyc), .ext_clk_i(pin),
    .sleep_i(sleep), .wdt_tick_i(wdt_in), .wdt_tick_o(wdt_out),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  function automatic logic [7:0] expect_inc(input logic [7:0] base, input int n, input int k);
    return (n >= 2) ? base + 8'((n - 2) >> k) : base;
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd1, v); chk("R1 option reset", v, 8'hFF);
    rd(2'd0, v); chk("R1 timer reset", v, 8'h00);
    rd(2'd2, v); chk("R1 intctl reset", v, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'hC8);
    rd(2'd1, v); chk("R2 option readback", v, 8'hC8);
    rd(2'd3, v); chk("R2 unused address", v, 8'h00);
  endtask

  task automatic t_holdoff;
    logic [7:0] v;
    wr(2'd1, 8'h08);
    step(3);
    wr(2'd0, 8'h40);
    step(2); rd(2'd0, v); chk("R7 hold two cycles", v, 8'h40);
    step(1); rd(2'd0, v); chk("R7 first increment", v, 8'h41);
    step(7); rd(2'd0, v); chk("R7 steady count", v, expect_inc(8'h40, 10, 0));
  endtask

  task automatic t_prescale(input logic [2:0] ps, input int n);
    logic [7:0] v;
    wr(2'd1, {5'b00000, ps});
    step(3);
    wr(2'd0, 8'h00);
    step(n);
    rd(2'd0, v);
    chk($sformatf("R5 timer divide tap %0d", ps), v, expect_inc(8'h00, n, int'(ps) + 1));
  endtask

  task automatic t_cyc;
    logic [7:0] v;
    wr(2'd1, 8'h08);
    cyc = 1'b0;
    step(2);
    wr(2'd0, 8'h50);
    step(20); rd(2'd0, v); chk("R3 no tick no count", v, 8'h50);
    cyc = 1'b1;
    step(12); rd(2'd0, v); chk("R3 ticks counted", v, 8'h5A);
  endtask

  task automatic t_edge;
    logic [7:0] v;
    pin = 1'b0;
    wr(2'd1, 8'h28);
    step(5);
    wr(2'd0, 8'h10);
    step(3);
    pin = 1'b1; step(8); rd(2'd0, v); chk("R4 rising counted", v, 8'h11);
    pin = 1'b0; step(8); rd(2'd0, v); chk("R4 falling ignored", v, 8'h11);
    wr(2'd1, 8'h38);
    step(5);
    wr(2'd0, 8'h20);
    step(3);
    pin = 1'b1; step(8); rd(2'd0, v); chk("R4 rising ignored", v, 8'h20);
    pin = 1'b0; step(8); rd(2'd0, v); chk("R4 falling counted", v, 8'h21);
    for (int i = 0; i < 5; i++) begin
      pin = 1'b1; step(6);
      pin = 1'b0; step(6);
    end
    rd(2'd0, v); chk("R4 pulse train", v, 8'h26);
  endtask

  task automatic t_sleep;
    logic [7:0] v;
    wr(2'd1, 8'h08);
    sleep = 1'b1;
    step(1);
    wr(2'd0, 8'h30);
    step(20); rd(2'd0, v); chk("R10 frozen in sleep", v, 8'h30);
    sleep = 1'b0;
    step(10); rd(2'd0, v); chk("R10 resumes after sleep", v, 8'h38);
  endtask

  task automatic t_wdt;
    int cnt;
    wr(2'd1, 8'h0A);
    wdt_in = 1'b1;
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      #2; if (wdt_out) cnt++;
      @(negedge clk);
    end
    wdt_in = 1'b0;
    chk("R6 watchdog divide by 4", 8'(cnt), 8'd4);
    wr(2'd1, 8'h02);
    wdt_in = 1'b1; sleep = 1'b1;
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      #2; if (wdt_out) cnt++;
      @(negedge clk);
    end
    wdt_in = 1'b0; sleep = 1'b0;
    chk("R6 R10 watchdog direct in sleep", 8'(cnt), 8'd16);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFE);
    step(3);
    rd(2'd0, v); chk("R8 before wrap", v, 8'hFF);
    rd(2'd2, v); chk("R8 flag clear before wrap", v, 8'h00);
    step(1);
    rd(2'd0, v); chk("R8 wrapped", v, 8'h00);
    rd(2'd2, v); chk("R8 flag set on wrap", v, 8'h01);
    chk("R9 masked irq", {7'd0, irq}, 8'h00);
    step(20);
    rd(2'd2, v); chk("R8 flag sticky", v, 8'h01);
    wr(2'd2, 8'h03);
    chk("R9 irq enabled", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h02);
    chk("R9 irq after clear", {7'd0, irq}, 8'h00);
    rd(2'd2, v); chk("R8 flag cleared by write", v, 8'h02);
    wr(2'd0, 8'hFF);
    step(3);
    chk("R9 irq on wrap", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_holdoff;
    t_prescale(3'd0, 20);
    t_prescale(3'd2, 40);
    t_prescale(3'd7, 600);
    t_cyc;
    t_edge;
    t_sleep;
    t_wdt;
    t_irq;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule